// File: doc/BRIEF.md
# Shared Tracking Discriminator

This block is a single fixed-point discriminator that several receiver channels share in turn. Once per 1 ms integration period, each channel raises a request and presents its signed in-phase (I) and quadrature (Q) prompt sums. The block picks one pending channel at a time in rotating order and acknowledges it. It then computes two values for that channel. The first is a cheap vector-magnitude estimate. The second is a small-angle carrier phase error, taken as the quotient Q/I in fixed point. It returns both values with the channel number on a one-cycle result strobe.

The arctangent is replaced by the plain ratio, and the square root by a max-plus-quarter-min estimate. This leaves only absolute values, a compare, a shift and a bit-serial restoring divider. One service takes well under 32 clock cycles. All channels are therefore handled long before any channel's next sums arrive. The loop filters that consume the results sit outside this block.

Top module: `trk_discrim_shared`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, `res_vld` and every bit of `req_ack` are 0.
- R2: `req_ack` is a one-cycle pulse with at most one bit set. A bit is set only for a channel whose `req_vld` was high in the previous cycle.
- R3: Channels are served in rotating order. The next grant goes to the first pending channel above the last granted index, wrapping from NUM_CH-1 to 0. After reset the order starts at channel 0.
- R4: Only one request is in service at a time. No acknowledgement is issued between a grant and its result. Each grant produces exactly one result, and its `res_ch` equals the granted index.
- R5: `res_mag` is the unsigned value max(|I|,|Q|) + floor(min(|I|,|Q|)/4), with |-32768| taken as 32768. The largest value is 40960.
- R6: `res_phase` is a signed two's-complement value with 8 fractional bits. Its magnitude is floor(|Q|*256/|I|), and it is negative exactly when Q and I have opposite signs and that magnitude is nonzero.
- R7: When the magnitude from R6 exceeds 32767, the magnitude is clamped to 32767 with the sign from R6. The value -32768 is never produced.
- R8: When I is zero, `res_phase` is +32767 if Q >= 0 and -32767 if Q < 0.
- R9: The result strobe for a channel follows its acknowledgement within 32 clock cycles.
- R10: `res_vld` is high for exactly one cycle per result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NUM_CH | Per-channel request; held high until acknowledged |
| req_i | input | NUM_CH*DATA_W | Packed signed in-phase sums, channel k at bits k*DATA_W upward |
| req_q | input | NUM_CH*DATA_W | Packed signed quadrature sums, same packing |
| req_ack | output | NUM_CH | One-hot pulse; the channel's operands have been taken |
| res_vld | output | 1 | One-cycle result strobe |
| res_ch | output | CH_W | Channel index of the result |
| res_mag | output | DATA_W+1 | Magnitude estimate |
| res_phase | output | PH_W | Signed phase error, 8 fractional bits |

## Verification
A channel's result can be returned while the same channel raises a fresh request. Arbitration and result return are then both at stake in that one cycle. The bench provokes this by reissuing channel 0's request in the very cycle its result strobe is seen, while two other channels are still pending. It then checks that the rotating pointer serves those two first and returns to channel 0 last. It also checks that every result still carries the right tag and values, and that no second acknowledgement overlaps a service in flight.

// File: rtl/trk_pkg.sv
package trk_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_DIV  = 1'b1
  } trk_state_e;

endpackage

// File: rtl/trk_rr_arb.sv
module trk_rr_arb #(
  parameter int N = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 take,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] sel,
  output logic                 any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] last_q;

  // first pending index strictly after last_q, wrapping
  always_comb begin
    gnt = '0;
    sel = '0;
    any = 1'b0;
    for (int off = 1; off <= N; off++) begin
      int idx;
      idx = (int'(last_q) + off) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        sel      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (take) last_q <= sel;
  end

endmodule

// File: rtl/trk_mag_est.sv
module trk_mag_est #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] i_val,
  input  logic signed [DW-1:0] q_val,
  output logic [DW:0]          abs_i,
  output logic [DW:0]          abs_q,
  output logic [DW:0]          mag
);
  function automatic logic [DW:0] absv(input logic signed [DW-1:0] v);
    logic [DW:0] ext;
    ext = {v[DW-1], v};
    return v[DW-1] ? (~ext + 1'b1) : ext;
  endfunction

  function automatic logic [DW:0] max_quarter_min(input logic [DW:0] a, input logic [DW:0] b);
    logic [DW:0] hi, lo;
    hi = (a >= b) ? a : b;
    lo = (a >= b) ? b : a;
    return hi + (lo >> 2);
  endfunction

  always_comb begin
    abs_i = absv(i_val);
    abs_q = absv(q_val);
    mag   = max_quarter_min(abs_i, abs_q);
  end

endmodule

// File: rtl/trk_restoring_div.sv
module trk_restoring_div #(
  parameter int NW  = 25,
  parameter int DVW = 17
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [NW-1:0]  quot
);
  localparam int CW = $clog2(NW + 1);

  logic [DVW-1:0] rem_q;
  logic [DVW-1:0] dvs_q;
  logic [NW-1:0]  shf_q;
  logic [CW-1:0]  cnt_q;
  logic [DVW:0]   trial;
  logic           fits;

  assign trial = {rem_q, shf_q[NW-1]};
  assign fits  = trial >= {1'b0, dvs_q};
  assign quot  = shf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      shf_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        dvs_q <= divisor;
        shf_q <= dividend;
        cnt_q <= CW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? DVW'(trial - {1'b0, dvs_q}) : trial[DVW-1:0];
        shf_q <= {shf_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trk_discrim_shared.sv
module trk_discrim_shared #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int PH_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CH-1:0]           req_vld,
  input  logic [NUM_CH*DATA_W-1:0]    req_i,
  input  logic [NUM_CH*DATA_W-1:0]    req_q,
  output logic [NUM_CH-1:0]           req_ack,
  output logic                        res_vld,
  output logic [$clog2(NUM_CH)-1:0]   res_ch,
  output logic [DATA_W:0]             res_mag,
  output logic signed [PH_W-1:0]      res_phase
);
  import trk_pkg::*;

  localparam int CH_W  = $clog2(NUM_CH);
  localparam int MAG_W = DATA_W + 1;
  localparam int NUM_W = MAG_W + FRAC_W;
  localparam int PMAX  = 2 ** (PH_W - 1) - 1;

  // clamp the raw quotient and apply the sign rules
  function automatic logic [PH_W-1:0] fold_phase(input logic [NUM_W-1:0] quo,
                                                 input logic neg_q, input logic neg_i,
                                                 input logic i_zero);
    logic [PH_W-1:0] m;
    m = (quo > NUM_W'(PMAX)) ? PH_W'(PMAX) : quo[PH_W-1:0];
    if (i_zero)          return neg_q ? (~PH_W'(PMAX) + 1'b1) : PH_W'(PMAX);
    if (neg_q ^ neg_i)   return ~m + 1'b1;
    return m;
  endfunction

  trk_state_e state_q;

  logic [NUM_CH-1:0] arb_gnt;
  logic [CH_W-1:0]   arb_sel;
  logic              arb_any;
  logic              grant_fire;
  logic              div_done;
  logic              div_busy;
  logic [NUM_W-1:0]  div_quot;

  logic signed [DATA_W-1:0] sel_i, sel_q;
  logic [MAG_W-1:0]         abs_i, abs_q, mag_est;

  logic [CH_W-1:0]  ch_q;
  logic [MAG_W-1:0] mag_q;
  logic             neg_i_q, neg_q_q, izero_q;

  assign grant_fire = (state_q == ST_IDLE) && arb_any;
  assign sel_i      = req_i[int'(arb_sel)*DATA_W +: DATA_W];
  assign sel_q      = req_q[int'(arb_sel)*DATA_W +: DATA_W];

  trk_rr_arb #(.N(NUM_CH)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_vld),
    .take (grant_fire),
    .gnt  (arb_gnt),
    .sel  (arb_sel),
    .any  (arb_any)
  );

  trk_mag_est #(.DW(DATA_W)) u_mag (
    .i_val(sel_i),
    .q_val(sel_q),
    .abs_i(abs_i),
    .abs_q(abs_q),
    .mag  (mag_est)
  );

  trk_restoring_div #(.NW(NUM_W), .DVW(MAG_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (grant_fire),
    .dividend({abs_q, {FRAC_W{1'b0}}}),
    .divisor (abs_i),
    .busy    (div_busy),
    .done    (div_done),
    .quot    (div_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_ack   <= '0;
      ch_q      <= '0;
      mag_q     <= '0;
      neg_i_q   <= 1'b0;
      neg_q_q   <= 1'b0;
      izero_q   <= 1'b0;
      res_vld   <= 1'b0;
      res_ch    <= '0;
      res_mag   <= '0;
      res_phase <= '0;
    end else begin
      req_ack <= grant_fire ? arb_gnt : '0;
      res_vld <= 1'b0;
      case (state_q)
        ST_IDLE: if (grant_fire) begin
          state_q <= ST_DIV;
          ch_q    <= arb_sel;
          mag_q   <= mag_est;
          neg_i_q <= sel_i[DATA_W-1];
          neg_q_q <= sel_q[DATA_W-1];
          izero_q <= (sel_i == '0);
        end
        ST_DIV: if (div_done) begin
          state_q   <= ST_IDLE;
          res_vld   <= 1'b1;
          res_ch    <= ch_q;
          res_mag   <= mag_q;
          res_phase <= $signed(fold_phase(div_quot, neg_q_q, neg_i_q, izero_q));
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trk_discrim_chk.sv
module trk_discrim_chk #(
  parameter int NUM_CH = 6,
  parameter int DATA_W = 16,
  parameter int PH_W   = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CH-1:0]         req_vld,
  input logic [NUM_CH-1:0]         req_ack,
  input logic                      res_vld,
  input logic [$clog2(NUM_CH)-1:0] res_ch,
  input logic [DATA_W:0]           res_mag,
  input logic signed [PH_W-1:0]    res_phase,
  input logic                      grant_fire,
  input logic                      div_done
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int MAG_TOP = 2 ** (DATA_W - 1) + 2 ** (DATA_W - 3);

  logic            inflight_q;
  logic [CH_W-1:0] last_q;
  logic [5:0]      lat_q;
  logic [CH_W-1:0] ack_idx;

  always_comb begin
    ack_idx = '0;
    for (int k = 0; k < NUM_CH; k++) if (req_ack[k]) ack_idx = CH_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
      last_q     <= '0;
      lat_q      <= '0;
    end else if (|req_ack) begin
      inflight_q <= 1'b1;
      last_q     <= ack_idx;
      lat_q      <= '0;
    end else if (res_vld) begin
      inflight_q <= 1'b0;
    end else if (inflight_q && lat_q != 6'h3f) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack));

  p_ack_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ack) |-> ((req_ack & $past(req_vld)) == req_ack));

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ack) |=> (req_ack == '0));

  p_one_inflight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ack) |-> !inflight_q);

  p_result_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (inflight_q && res_ch == last_q));

  p_done_to_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> res_vld);

  p_no_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> !inflight_q || res_vld);

  p_mag_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (int'(res_mag) <= MAG_TOP));

  p_no_min_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_phase != {1'b1, {(PH_W-1){1'b0}}}));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q |-> (lat_q < 6'd32));

  p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);

endmodule

bind trk_discrim_shared trk_discrim_chk #(
  .NUM_CH(NUM_CH),
  .DATA_W(DATA_W),
  .PH_W  (PH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_ack   (req_ack),
  .res_vld   (res_vld),
  .res_ch    (res_ch),
  .res_mag   (res_mag),
  .res_phase (res_phase),
  .grant_fire(grant_fire),
  .div_done  (div_done)
);

// File: tb/test_trk_discrim_shared.sv
`timescale 1ns/1ps
module test_trk_discrim_shared;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  req_vld = '0;
  logic [NCH*DW-1:0] req_i = '0, req_q = '0;
  logic [NCH-1:0]  req_ack;
  logic            res_vld;
  logic [2:0]      res_ch;
  logic [DW:0]     res_mag;
  logic signed [15:0] res_phase;

  always #4 clk = ~clk;

  trk_discrim_shared i_trk_discrim_shared (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_i(req_i), .req_q(req_q),
    .req_ack(req_ack), .res_vld(res_vld), .res_ch(res_ch), .res_mag(res_mag),
    .res_phase(res_phase)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_ack = 0, n_res = 0, last_gnt = NCH - 1;
  int ack_log[64], ack_cyc[64];
  int r_ch[64], r_mag[64], r_ph[64], r_cyc[64];
  int op_i[NCH], op_q[NCH];
  int bad_ack = 0, dbl_res = 0;
  bit prev_res = 0, reissue_en = 0, done_flag = 0;
  int reissue_ch = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v); return v < 0 ? -v : v; endfunction

  function automatic int want_mag(input int i, input int q);
    int a = iabs(i), b = iabs(q);
    return (a > b) ? a + b / 4 : b + a / 4;
  endfunction

  function automatic int want_phase(input int i, input int q);
    longint n;
    if (i == 0) return (q < 0) ? -32767 : 32767;
    n = (longint'(iabs(q)) * 256) / iabs(i);
    if (n > 32767) n = 32767;
    return ((q < 0) != (i < 0)) ? -int'(n) : int'(n);
  endfunction

  function automatic int next_rr(input bit [NCH-1:0] pend, input int last);
    for (int off = 1; off <= NCH; off++)
      if (pend[(last + off) % NCH]) return (last + off) % NCH;
    return -1;
  endfunction

  // monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if ($countones(req_ack) > 1) bad_ack++;
      for (int k = 0; k < NCH; k++) if (req_ack[k]) begin
        if (!req_vld[k]) bad_ack++;
        req_vld[k] = 1'b0;
        ack_log[n_ack] = k; ack_cyc[n_ack] = cyc; n_ack++;
        last_gnt = k;
      end
      if (res_vld && prev_res) dbl_res++;
      prev_res = res_vld;
      if (res_vld) begin
        r_ch[n_res] = res_ch; r_mag[n_res] = res_mag;
        r_ph[n_res] = res_phase; r_cyc[n_res] = cyc; n_res++;
        if (reissue_en && int'(res_ch) == reissue_ch) begin
          req_vld[reissue_ch] = 1'b1;
          reissue_en = 1'b0;
        end
      end
    end
  end

  task automatic post(input int ch, input int i, input int q);
    op_i[ch] = i; op_q[ch] = q;
    req_i[ch*DW +: DW] = 16'(i);
    req_q[ch*DW +: DW] = 16'(q);
    req_vld[ch] = 1'b1;
  endtask

  task automatic wait_res(input int n);
    for (int t = 0; t < 2000 && n_res < n; t++) @(negedge clk);
    chk(n_res >= n, "R4", "result count", n_res, n);
  endtask

  task automatic check_res(input int k, input string ph_tag);
    int ch = r_ch[k];
    chk(r_ch[k] == ack_log[k], "R4", "result tag", r_ch[k], ack_log[k]);
    chk(r_mag[k] == want_mag(op_i[ch], op_q[ch]), "R5", "magnitude", r_mag[k], want_mag(op_i[ch], op_q[ch]));
    chk(r_ph[k] == want_phase(op_i[ch], op_q[ch]), ph_tag, "phase", r_ph[k], want_phase(op_i[ch], op_q[ch]));
    chk(r_cyc[k] - ack_cyc[k] <= 32, "R9", "latency", r_cyc[k] - ack_cyc[k], 32);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(res_vld == 1'b0, "R1", "res_vld in reset", res_vld, 0);
    chk(req_ack == '0, "R1", "req_ack in reset", req_ack, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(res_vld == 1'b0 && req_ack == '0, "R1", "idle after reset", res_vld, 0);
  endtask

  task automatic t_single(input int ch, input int i, input int q, input string tag);
    int base = n_res;
    post(ch, i, q);
    wait_res(base + 1);
    check_res(base, tag);
  endtask

  task automatic t_all_rr();
    int base = n_res, last = last_gnt;
    bit [NCH-1:0] pend = '1;
    for (int c = 0; c < NCH; c++) post(c, 1000 * (c + 1) - 2500, 700 - 300 * c);
    wait_res(base + NCH);
    for (int k = 0; k < NCH; k++) begin
      int g = next_rr(pend, last);
      chk(ack_log[base + k] == g, "R3", "grant order (all)", ack_log[base + k], g);
      pend[g] = 1'b0; last = g;
      check_res(base + k, "R6");
    end
  endtask

  task automatic t_partial_rr();
    int base = n_res, last = last_gnt;
    bit [NCH-1:0] pend = 6'b011010;
    post(1, -50, -9); post(3, 123, 4567); post(4, -32768, -32768);
    wait_res(base + 3);
    for (int k = 0; k < 3; k++) begin
      int g = next_rr(pend, last);
      chk(ack_log[base + k] == g, "R3", "grant order (sparse)", ack_log[base + k], g);
      pend[g] = 1'b0; last = g;
      check_res(base + k, "R7");
    end
  endtask

  // result return and a fresh request of the same channel in one cycle
  task automatic t_collide();
    int base = n_res, last = last_gnt;
    bit [NCH-1:0] pend = 6'b000111;
    bit again = 1'b1;
    reissue_ch = 0; reissue_en = 1'b1;
    post(0, 300, -77); post(1, -8, 8); post(2, 5, 1);
    wait_res(base + 4);
    for (int k = 0; k < 4; k++) begin
      int g = next_rr(pend, last);
      chk(ack_log[base + k] == g, "R3", "grant order (collide)", ack_log[base + k], g);
      pend[g] = 1'b0; last = g;
      if (g == 0 && again) begin pend[0] = 1'b1; again = 1'b0; end
      check_res(base + k, "R6");
    end
  endtask

  initial begin
    t_reset();
    t_single(0, 1000, 250, "R6");
    t_single(2, -300, 600, "R6");
    t_single(5, 7, -3, "R6");
    t_single(3, -32768, -32768, "R6");
    t_single(1, 1, 2000, "R7");
    t_single(4, -2, 30000, "R7");
    t_single(0, 0, 5, "R8");
    t_single(2, 0, -5, "R8");
    t_single(3, 0, 0, "R8");
    t_all_rr();
    t_partial_rr();
    t_collide();
    repeat (40) @(negedge clk);
    chk(n_res == n_ack, "R4", "one result per grant", n_res, n_ack);
    chk(bad_ack == 0, "R2", "ack one-hot to requester", bad_ack, 0);
    chk(dbl_res == 0, "R10", "strobe width", dbl_res, 0);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule